// File: doc/BRIEF.md
# Scaled-index effective address generator

This unit turns the already-split addressing fields of a 32-bit instruction into a memory effective address. It takes the two-bit mode field, the three-bit r/m field, the scale-index-base byte and a 32-bit displacement word. It reads the register values it needs through two combinational register-file read ports, one for the base and one for the index. It then forms base + (index << scale) + displacement. The sum wraps modulo 2^32.

When the mode field says the operand is a register (mode 11), no address is formed. The unit instead raises a register-operand flag and reports the register number.

The unit handles three encodings that remove a term from the sum:
- An index code of 100 removes the index and its scale.
- Mode 00 with r/m 101 gives the displacement alone.
- Inside a scale-index-base form, mode 00 with a base code of 101 puts the 32-bit displacement in place of the base register.

All results appear one clock after the request, together with a valid flag.

Top module: `eag_unit`

## Requirements
- R1: A scale-index-base byte is used exactly when mode is not 11 and r/m is 100. Its fields are scale = bits [7:6], index = bits [5:3] and base = bits [2:0]. In that form the base read port selects the base field and the index read port selects the index field.
- R2: Scale codes 00, 01, 10 and 11 multiply the index register value by 1, 2, 4 and 8.
- R3: An index field of 100 removes both the index and the scale from the sum, so the address is the base term plus the displacement term.
- R4: Without a scale-index-base byte (and mode not 11), the base read select equals r/m, so codes 000..111 pick registers 0..7. The address uses that register as its base.
- R5: Mode 00 with r/m 101 gives an address equal to the full 32-bit displacement, with no register added.
- R6: Mode 11 sets the register-operand flag, sets the register-number output to r/m, and drives the address to zero.
- R7: Mode 01 adds the low 8 displacement bits, sign-extended to 32 bits. Mode 10 adds the full 32-bit displacement. Mode 00 adds no displacement, except in the cases of R5 and R8.
- R8: In a scale-index-base form with mode 00 and base field 101, the full 32-bit displacement replaces the base register term, and the index term still applies.
- R9: The outputs update on the clock edge after a cycle with the request valid high, and the output valid flag is then high. The output valid flag is low in the cycle after a cycle with no request, and it is low out of reset.
- R10: The address sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| mod_i | input | 2 | Addressing mode field |
| rm_i | input | 3 | r/m field |
| sib_i | input | 8 | Scale-index-base byte |
| disp_i | input | 32 | Displacement word; low 8 bits used for the short form |
| base_sel_o | output | 3 | Register-file read select for the base |
| base_val_i | input | 32 | Register value at base_sel_o |
| idx_sel_o | output | 3 | Register-file read select for the index |
| idx_val_i | input | 32 | Register value at idx_sel_o |
| out_valid | output | 1 | Result valid |
| ea_addr_o | output | 32 | Effective address |
| ea_is_reg_o | output | 1 | Operand is a register (mode 11) |
| ea_reg_o | output | 3 | Register number when ea_is_reg_o is high |

## Verification
There is only one register stage, so a wrong decode shows up at the outputs on the very next cycle. A mis-decoded special encoding appears as an address that is off by exactly one term: a base value, a scaled index value, or a displacement. A wrong shift amount gives an index contribution that is off by a power of two. A stuck valid register shows as out_valid high after an idle cycle, or low after a request. Random operands on all eight registers separate each of these errors from the expected sums.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [1:0] {
    DISP_NONE  = 2'd0,
    DISP_SHORT = 2'd1,
    DISP_FULL  = 2'd2
  } disp_kind_e;

  localparam logic [1:0] MODE_NODISP = 2'b00;
  localparam logic [1:0] MODE_SHORT  = 2'b01;
  localparam logic [1:0] MODE_FULL   = 2'b10;
  localparam logic [1:0] MODE_REG    = 2'b11;

  localparam logic [2:0] CODE_SIB    = 3'b100;
  localparam logic [2:0] CODE_NOIDX  = 3'b100;
  localparam logic [2:0] CODE_NOBASE = 3'b101;

  function automatic logic is_sib_form(logic [1:0] md, logic [2:0] rm);
    return (md != MODE_REG) && (rm == CODE_SIB);
  endfunction

  function automatic disp_kind_e pick_disp(logic [1:0] md, logic no_base);
    case (md)
      MODE_SHORT: return DISP_SHORT;
      MODE_FULL:  return DISP_FULL;
      MODE_NODISP: return no_base ? DISP_FULL : DISP_NONE;
      default:    return DISP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic [1:0]       mod_i,
  input  logic [2:0]       rm_i,
  input  logic [7:0]       sib_i,
  output logic             is_reg_o,
  output logic             use_base_o,
  output logic             use_index_o,
  output logic [1:0]       scale_o,
  output disp_kind_e       disp_kind_o,
  output logic [SEL_W-1:0] base_sel_o,
  output logic [SEL_W-1:0] idx_sel_o
);
  logic       sib_form;
  logic [2:0] f_base, f_index;
  logic       no_base;

  assign f_base   = sib_i[2:0];
  assign f_index  = sib_i[5:3];
  assign sib_form = is_sib_form(mod_i, rm_i);

  always_comb begin
    is_reg_o    = (mod_i == MODE_REG);
    no_base     = 1'b0;
    use_index_o = 1'b0;
    base_sel_o  = SEL_W'(rm_i);
    if (sib_form) begin
      base_sel_o  = SEL_W'(f_base);
      no_base     = (mod_i == MODE_NODISP) && (f_base == CODE_NOBASE);
      use_index_o = (f_index != CODE_NOIDX);
    end else if (!is_reg_o) begin
      no_base = (mod_i == MODE_NODISP) && (rm_i == CODE_NOBASE);
    end
    use_base_o  = !is_reg_o && !no_base;
    disp_kind_o = is_reg_o ? DISP_NONE : pick_disp(mod_i, no_base);
  end

  assign idx_sel_o = SEL_W'(f_index);
  assign scale_o   = sib_i[7:6];

endmodule

// File: rtl/eag_sum.sv
module eag_sum
  import eag_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned D8W = 8
) (
  input  logic          use_base_i,
  input  logic          use_index_i,
  input  logic [1:0]    scale_i,
  input  disp_kind_e    disp_kind_i,
  input  logic [AW-1:0] base_val_i,
  input  logic [AW-1:0] idx_val_i,
  input  logic [AW-1:0] disp_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_term, idx_term, disp_term, disp_short;

  generate
    if (AW > D8W) begin : g_sext
      assign disp_short = {{(AW-D8W){disp_i[D8W-1]}}, disp_i[D8W-1:0]};
    end else begin : g_nosext
      assign disp_short = disp_i;
    end
  endgenerate

  always_comb begin
    base_term = use_base_i  ? base_val_i : '0;
    idx_term  = use_index_i ? (idx_val_i << scale_i) : '0;
    case (disp_kind_i)
      DISP_SHORT: disp_term = disp_short;
      DISP_FULL:  disp_term = disp_i;
      default:    disp_term = '0;
    endcase
  end

  assign addr_o = base_term + idx_term + disp_term;

endmodule

// File: rtl/eag_pipe.sv
module eag_pipe #(
  parameter int unsigned AW    = 32,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [AW-1:0]    addr_i,
  input  logic             is_reg_i,
  input  logic [SEL_W-1:0] reg_i,
  output logic             out_valid,
  output logic [AW-1:0]    addr_o,
  output logic             is_reg_o,
  output logic [SEL_W-1:0] reg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o   <= '0;
      is_reg_o <= 1'b0;
      reg_o    <= '0;
    end else if (in_valid) begin
      addr_o   <= addr_i;
      is_reg_o <= is_reg_i;
      reg_o    <= reg_i;
    end
  end

endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NREG  = 8,
  parameter int unsigned D8W   = 8,
  localparam int unsigned SEL_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mod_i,
  input  logic [2:0]       rm_i,
  input  logic [7:0]       sib_i,
  input  logic [AW-1:0]    disp_i,
  output logic [SEL_W-1:0] base_sel_o,
  input  logic [AW-1:0]    base_val_i,
  output logic [SEL_W-1:0] idx_sel_o,
  input  logic [AW-1:0]    idx_val_i,
  output logic             out_valid,
  output logic [AW-1:0]    ea_addr_o,
  output logic             ea_is_reg_o,
  output logic [SEL_W-1:0] ea_reg_o
);
  logic       is_reg_w, use_base_w, use_index_w;
  logic [1:0] scale_w;
  disp_kind_e disp_kind_w;
  logic [AW-1:0] addr_w;

  eag_decode #(.SEL_W(SEL_W)) dec_i (
    .mod_i(mod_i), .rm_i(rm_i), .sib_i(sib_i),
    .is_reg_o(is_reg_w), .use_base_o(use_base_w), .use_index_o(use_index_w),
    .scale_o(scale_w), .disp_kind_o(disp_kind_w),
    .base_sel_o(base_sel_o), .idx_sel_o(idx_sel_o)
  );

  eag_sum #(.AW(AW), .D8W(D8W)) sum_i (
    .use_base_i(use_base_w), .use_index_i(use_index_w), .scale_i(scale_w),
    .disp_kind_i(disp_kind_w), .base_val_i(base_val_i), .idx_val_i(idx_val_i),
    .disp_i(disp_i), .addr_o(addr_w)
  );

  eag_pipe #(.AW(AW), .SEL_W(SEL_W)) pipe_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .addr_i(addr_w), .is_reg_i(is_reg_w), .reg_i(SEL_W'(rm_i)),
    .out_valid(out_valid), .addr_o(ea_addr_o),
    .is_reg_o(ea_is_reg_o), .reg_o(ea_reg_o)
  );

endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  mod_i,
  input logic [2:0]  rm_i,
  input logic [7:0]  sib_i,
  input logic [31:0] disp_i,
  input logic [2:0]  base_sel_o,
  input logic [31:0] base_val_i,
  input logic [2:0]  idx_sel_o,
  input logic [31:0] idx_val_i,
  input logic        out_valid,
  input logic [31:0] ea_addr_o,
  input logic        ea_is_reg_o,
  input logic [2:0]  ea_reg_o
);
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_reg_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_i == 2'b11) |=>
      (ea_is_reg_o && ea_reg_o == $past(rm_i) && ea_addr_o == 32'd0));

  p_absolute_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_i == 2'b00 && rm_i == 3'b101) |=>
      (!ea_is_reg_o && ea_addr_o == $past(disp_i)));

  p_base_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_i != 2'b11 && rm_i != 3'b100) |-> base_sel_o == rm_i);

  p_sib_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_i != 2'b11 && rm_i == 3'b100) |->
      (base_sel_o == sib_i[2:0] && idx_sel_o == sib_i[5:3]));

  p_index_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_i == 2'b00 && rm_i == 3'b100 &&
     sib_i[5:3] == 3'b100 && sib_i[2:0] != 3'b101) |=>
      ea_addr_o == $past(base_val_i));

  p_short_disp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_i == 2'b01 && rm_i != 3'b100) |=>
      ea_addr_o == $past(base_val_i + {{24{disp_i[7]}}, disp_i[7:0]}));

endmodule

bind eag_unit eag_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mod_i(mod_i), .rm_i(rm_i),
  .sib_i(sib_i), .disp_i(disp_i), .base_sel_o(base_sel_o),
  .base_val_i(base_val_i), .idx_sel_o(idx_sel_o), .idx_val_i(idx_val_i),
  .out_valid(out_valid), .ea_addr_o(ea_addr_o), .ea_is_reg_o(ea_is_reg_o),
  .ea_reg_o(ea_reg_o)
);

// File: tb/eag_unit_tb.sv
module eag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mod_i = '0;
  logic [2:0]  rm_i = '0;
  logic [7:0]  sib_i = '0;
  logic [31:0] disp_i = '0;
  logic [2:0]  base_sel, idx_sel;
  logic [31:0] base_val, idx_val;
  logic        out_valid, ea_is_reg;
  logic [31:0] ea_addr;
  logic [2:0]  ea_reg;
  logic [31:0] rf [8];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign base_val = rf[base_sel];
  assign idx_val  = rf[idx_sel];

  eag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mod_i(mod_i), .rm_i(rm_i),
    .sib_i(sib_i), .disp_i(disp_i), .base_sel_o(base_sel), .base_val_i(base_val),
    .idx_sel_o(idx_sel), .idx_val_i(idx_val), .out_valid(out_valid),
    .ea_addr_o(ea_addr), .ea_is_reg_o(ea_is_reg), .ea_reg_o(ea_reg)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [1:0] md, logic [2:0] rm,
                                        logic [7:0] sb, logic [31:0] d);
    logic [31:0] dterm, bterm, iterm;
    if (md == 2'd3) return 32'd0;
    dterm = (md == 2'd1) ? 32'($signed(d[7:0])) : (md == 2'd2) ? d : 32'd0;
    if (rm != 3'd4) begin
      if (md == 2'd0 && rm == 3'd5) return d;
      return rf[rm] + dterm;
    end
    bterm = (md == 2'd0 && sb[2:0] == 3'd5) ? d : rf[sb[2:0]];
    iterm = (sb[5:3] == 3'd4) ? 32'd0 : rf[sb[5:3]] * (32'd1 << sb[7:6]);
    return bterm + iterm + dterm;
  endfunction

  task automatic op(string tag, logic [1:0] md, logic [2:0] rm,
                    logic [7:0] sb, logic [31:0] d);
    logic [31:0] exp;
    @(negedge clk);
    mod_i = md; rm_i = rm; sib_i = sb; disp_i = d; in_valid = 1'b1;
    exp = model(md, rm, sb, d);
    #1;
    if (md != 2'd3 && rm != 3'd4) chk({tag, " R4 base select"}, 32'(base_sel), 32'(rm));
    if (md != 2'd3 && rm == 3'd4) chk({tag, " R1 index select"}, 32'(idx_sel), 32'(sb[5:3]));
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, 32'(out_valid), 32'd1);
    chk({tag, " addr"}, ea_addr, exp);
    chk({tag, " R6 reg flag"}, 32'(ea_is_reg), 32'(md == 2'd3));
    if (md == 2'd3) chk({tag, " R6 reg num"}, 32'(ea_reg), 32'(rm));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 8; i++) rf[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0011;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++)
      op("R2 scale", 2'd0, 3'd4, {2'(s), 3'd2, 3'd1}, 32'h0);
    op("R1 sib mod1", 2'd1, 3'd4, 8'b01_110_111, 32'h0000_00F0);
    op("R3 index dropped", 2'd0, 3'd4, 8'b11_100_011, 32'h0);
    op("R3 index dropped mod2", 2'd2, 3'd4, 8'b10_100_000, 32'h0000_1234);
    for (int r = 0; r < 8; r++)
      if (r != 4) op("R4 base", 2'd2, 3'(r), 8'h00, 32'h0000_0010);
    op("R5 absolute", 2'd0, 3'd5, 8'hFF, 32'hDEAD_BEEF);
    op("R6 register", 2'd3, 3'd6, 8'hA5, 32'h1111_1111);
    op("R6 register sib code", 2'd3, 3'd4, 8'h00, 32'h0);
    op("R7 short negative", 2'd1, 3'd3, 8'h00, 32'h1234_5680);
    op("R7 short positive", 2'd1, 3'd0, 8'h00, 32'hFFFF_FF7F);
    op("R7 mod0 no disp", 2'd0, 3'd1, 8'h00, 32'hFFFF_FFFF);
    op("R8 sib no base", 2'd0, 3'd4, 8'b10_001_101, 32'h0040_0000);
    op("R8 sib no base no index", 2'd0, 3'd4, 8'b00_100_101, 32'h0BAD_F00D);
    rf[7] = 32'hFFFF_FFF0; rf[6] = 32'h8000_0000;
    op("R10 wrap", 2'd2, 3'd4, 8'b01_110_111, 32'h0000_0020);

    @(negedge clk);
    chk("R9 idle valid low", 32'(out_valid), 32'd0);

    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0)
        for (int i = 0; i < 8; i++) rf[i] = $urandom;
      op("R1 random", 2'($urandom), 3'($urandom), 8'($urandom), $urandom);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule